// File: doc/BRIEF.md
# Serial NOR Write Guard and Command Sequencer

This block is the permission and sequencing core of a serial NOR flash device model. A front end that has already shifted in a frame presents the opcode, the page-level target address, up to five bits of register data, and a flag telling whether the frame ended exactly after a whole byte, all with a one-cycle `cmd_valid` strobe that marks the chip-select rising edge. The block decides whether a program, erase, read or register write may proceed and reports its verdict one clock later as a `go_o` or `refuse_o` pulse.

Writes are gated by a write-enable latch, by a power-of-two sector range chosen by a four-bit protect level and a top/bottom select, and by a volatile lock bit per 64 KB sector. The block also tracks the single array operation in flight, lets it be suspended and resumed, holds sticky program and erase error flags, and performs a software reset only after a two-frame arm-then-fire handshake. The array engine reports `busy_i` while it works and `op_done`/`op_fail` when it stops.

Top module: `nor_write_guard`

## Requirements
- R1: Opcode 06h sets the write-enable latch and 04h clears it; a program (02h), sector erase (D8h), status write (01h), lock write (E5h) or address-mode change (B7h/E9h) arriving with the latch at 0 produces no pulse, no flag and no state change.
- R2: A frame with `cmd_aligned` low is discarded whole: no pulse, and latch, protect level, flags, locks and pending reset arm keep their values.
- R3: Status write 01h loads the protect level from data bits [3:0] and the top/bottom select from bit 4; the target sector is page bits [16:8]. Level 0 protects nothing; level n of 1 to 9 protects 2^(n-1) sectors, counted down from sector 511 when the select is 0 and up from sector 0 when it is 1; levels 10 to 15 protect all 512 sectors.
- R4: A program or erase with the latch set, no operation in flight and an unprotected, unlocked target gives a `go_o` pulse with kind 1 (program) or 2 (erase), and the latch stays 1; a protected or locked target gives a `refuse_o` pulse, sets the program or erase error flag and clears the latch.
- R5: Lock write E5h (latch set) stores data bit 0 into the lock bit of the addressed sector and clears the latch; all lock bits are 0 after reset.
- R6: Opcode 66h arms a reset; if the very next aligned frame is 99h, `soft_reset_o` pulses and the latch, lock bits, error flags, suspension, operation in flight and address mode clear, while protect level and select are kept; any other aligned opcode after 66h, even one ignored as busy, disarms it, and 99h without arming does nothing.
- R7: Opcode 75h while busy with an operation in flight enters suspension (`prog_susp_o` or `erase_susp_o` by its kind) and 7Ah leaves it; while suspended every program or erase request is refused with a `refuse_o` pulse, no flag and the latch unchanged.
- R8: Read 03h gives a `go_o` pulse of kind 0, except during program suspension when its page equals the suspended page, which gives `refuse_o`.
- R9: `op_done` for the operation in flight clears the latch; with `op_fail` high it sets the program or erase error flag of that operation's kind; opcode 50h clears both flags.
- R10: While `busy_i` is high and nothing is suspended, every opcode other than 75h leaves latch, flags, protect settings and outputs unchanged.
- R11: Opcodes B7h and E9h (latch set) set and clear the four-byte address mode and clear the latch.
- R12: Every output is registered: a verdict or state change appears on the clock edge that samples `cmd_valid` or `op_done`, and pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle strobe at the end of a frame |
| cmd_aligned | input | 1 | Frame ended right after a whole byte |
| cmd_op | input | 8 | Decoded opcode |
| cmd_page | input | ADDR_W-PAGE_LSB | Target address above the page offset |
| cmd_wdata | input | 5 | Register data carried by the frame |
| busy_i | input | 1 | Array engine is working |
| op_done | input | 1 | Array operation finished |
| op_fail | input | 1 | Finished operation failed |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 4 | Protect level |
| tb_o | output | 1 | Protect range counted from the bottom |
| addr4_o | output | 1 | Four-byte address mode |
| go_o | output | 1 | Request accepted (pulse) |
| go_kind_o | output | 2 | Kind of accepted request: 0 read, 1 program, 2 erase, 3 none |
| refuse_o | output | 1 | Request refused (pulse) |
| prog_err_o | output | 1 | Sticky program error flag |
| erase_err_o | output | 1 | Sticky erase error flag |
| prog_susp_o | output | 1 | Program suspended |
| erase_susp_o | output | 1 | Erase suspended |
| soft_reset_o | output | 1 | Software reset fired (pulse) |

## Verification
A wrong latch or protect value shows on `wel_o`, `bp_o` and `tb_o` one edge after the frame that corrupted it, and on the very next program or erase as a `go_o` where `refuse_o` was due, or the reverse. A stale lock bit or a lost reset arm stays invisible until a request hits that sector or a 99h arrives, so the stimulus aims requests at sectors 0, 255, 256, 510 and 511 and interleaves reset frames with other opcodes. A lost record of the operation in flight shows at the suspend flags and at reads of the suspended page.

// File: rtl/nwg_pkg.sv
package nwg_pkg;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_WRLOCK = 8'hE5;
    localparam logic [7:0] OP_RSTEN  = 8'h66;
    localparam logic [7:0] OP_RST    = 8'h99;
    localparam logic [7:0] OP_SUSP   = 8'h75;
    localparam logic [7:0] OP_RESUME = 8'h7A;
    localparam logic [7:0] OP_CLRFLG = 8'h50;
    localparam logic [7:0] OP_EN4B   = 8'hB7;
    localparam logic [7:0] OP_EX4B   = 8'hE9;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_PROG  = 2'd1,
        K_ERASE = 2'd2,
        K_NONE  = 2'd3
    } kind_e;

    typedef struct packed {
        logic wen;
        logic wdis;
        logic rd;
        logic prog;
        logic erase;
        logic wrsr;
        logic wrlock;
        logic rsten;
        logic rst;
        logic susp;
        logic resume;
        logic clrflg;
        logic en4b;
        logic ex4b;
    } cmd_cls_t;

endpackage

// File: rtl/nwg_cmd_decode.sv
module nwg_cmd_decode
    import nwg_pkg::*;
(
    input  logic [7:0] op,
    output cmd_cls_t   cls
);

    always_comb begin
        cls = '0;
        case (op)
            OP_WREN:   cls.wen    = 1'b1;
            OP_WRDI:   cls.wdis   = 1'b1;
            OP_READ:   cls.rd     = 1'b1;
            OP_PROG:   cls.prog   = 1'b1;
            OP_SERASE: cls.erase  = 1'b1;
            OP_WRSR:   cls.wrsr   = 1'b1;
            OP_WRLOCK: cls.wrlock = 1'b1;
            OP_RSTEN:  cls.rsten  = 1'b1;
            OP_RST:    cls.rst    = 1'b1;
            OP_SUSP:   cls.susp   = 1'b1;
            OP_RESUME: cls.resume = 1'b1;
            OP_CLRFLG: cls.clrflg = 1'b1;
            OP_EN4B:   cls.en4b   = 1'b1;
            OP_EX4B:   cls.ex4b   = 1'b1;
            default:   cls = '0;
        endcase
    end

endmodule

// File: rtl/nwg_prot_decode.sv
module nwg_prot_decode #(
    parameter int SEC_W = 9
) (
    input  logic [3:0]       bp,
    input  logic             tb,
    input  logic [SEC_W-1:0] sector,
    output logic             prot
);

    localparam int NSEC = 1 << SEC_W;
    localparam logic [SEC_W:0] NSEC_V = (SEC_W+1)'(NSEC);

    logic [SEC_W:0] span;
    logic [SEC_W:0] sec_x;

    assign sec_x = {1'b0, sector};

    // Number of protected sectors: 0, then powers of two, saturating at all.
    always_comb begin
        if (bp == 4'd0) begin
            span = '0;
        end else if ((int'(bp) - 1) >= SEC_W) begin
            span = NSEC_V;
        end else begin
            span = (SEC_W+1)'(1) << (bp - 4'd1);
        end
    end

    always_comb begin
        if (tb) begin
            prot = sec_x < span;
        end else begin
            prot = (span != '0) && (sec_x >= (NSEC_V - span));
        end
    end

endmodule

// File: rtl/nwg_lock_bank.sv
module nwg_lock_bank #(
    parameter int SEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [SEC_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [SEC_W-1:0] rd_idx,
    output logic             rd_lock
);

    localparam int NSEC = 1 << SEC_W;

    logic [NSEC-1:0] lock_q;
    logic [NSEC-1:0] lock_d;

    for (genvar i = 0; i < NSEC; i++) begin : g_bit
        always_comb begin
            if (clr_all) begin
                lock_d[i] = 1'b0;
            end else if (wr_en && (wr_idx == SEC_W'(i))) begin
                lock_d[i] = wr_val;
            end else begin
                lock_d[i] = lock_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign rd_lock = lock_q[rd_idx];

    // R5: a stored lock value reads back from the written sector.
    a_r5_lock_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> (lock_q[$past(wr_idx)] == $past(wr_val)));

    // R6: a software reset empties every lock bit.
    a_r6_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (lock_q == '0));

endmodule

// File: rtl/nor_write_guard.sv
module nor_write_guard
    import nwg_pkg::*;
#(
    parameter int ADDR_W   = 25,
    parameter int SEC_LSB  = 16,
    parameter int PAGE_LSB = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic                       cmd_aligned,
    input  logic [7:0]                 cmd_op,
    input  logic [ADDR_W-PAGE_LSB-1:0] cmd_page,
    input  logic [4:0]                 cmd_wdata,
    input  logic                       busy_i,
    input  logic                       op_done,
    input  logic                       op_fail,
    output logic                       wel_o,
    output logic [3:0]                 bp_o,
    output logic                       tb_o,
    output logic                       addr4_o,
    output logic                       go_o,
    output logic [1:0]                 go_kind_o,
    output logic                       refuse_o,
    output logic                       prog_err_o,
    output logic                       erase_err_o,
    output logic                       prog_susp_o,
    output logic                       erase_susp_o,
    output logic                       soft_reset_o
);

    localparam int PAGE_W = ADDR_W - PAGE_LSB;
    localparam int SEC_W  = ADDR_W - SEC_LSB;

    typedef struct packed {
        logic              wel;
        logic [3:0]        bp;
        logic              tb;
        logic              addr4;
        logic              perr;
        logic              eerr;
        logic              arm;
        logic              act_v;
        kind_e             act_kind;
        logic [PAGE_W-1:0] act_page;
        logic              susp;
        logic              go;
        kind_e             go_kind;
        logic              refuse;
        logic              srst;
    } state_t;

    state_t   st_q, st_d;
    cmd_cls_t cls;
    logic     prot_w;
    logic     lock_w;
    logic     lock_we;
    logic     lock_clr;
    logic     frame;
    logic     busy_now;
    logic [SEC_W-1:0] sec_w;

    assign sec_w    = cmd_page[PAGE_W-1 -: SEC_W];
    assign frame    = cmd_valid && cmd_aligned;
    assign busy_now = busy_i && !st_q.susp;

    nwg_cmd_decode u_dec (
        .op  (cmd_op),
        .cls (cls)
    );

    nwg_prot_decode #(.SEC_W(SEC_W)) u_prot (
        .bp     (st_q.bp),
        .tb     (st_q.tb),
        .sector (sec_w),
        .prot   (prot_w)
    );

    nwg_lock_bank #(.SEC_W(SEC_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (lock_clr),
        .wr_en   (lock_we),
        .wr_idx  (sec_w),
        .wr_val  (cmd_wdata[0]),
        .rd_idx  (sec_w),
        .rd_lock (lock_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.go      = 1'b0;
        st_d.go_kind = K_NONE;
        st_d.refuse  = 1'b0;
        st_d.srst    = 1'b0;
        lock_we      = 1'b0;
        lock_clr     = 1'b0;

        if (frame) begin
            // Any aligned frame other than the firing one drops the arm.
            if (!(cls.rst && st_q.arm)) begin
                st_d.arm = 1'b0;
            end
            if (busy_now) begin
                if (cls.susp && st_q.act_v) begin
                    st_d.susp = 1'b1;
                end
            end else if (cls.rsten) begin
                st_d.arm = 1'b1;
            end else if (cls.rst && st_q.arm) begin
                st_d.arm   = 1'b0;
                st_d.srst  = 1'b1;
                st_d.wel   = 1'b0;
                st_d.perr  = 1'b0;
                st_d.eerr  = 1'b0;
                st_d.susp  = 1'b0;
                st_d.act_v = 1'b0;
                st_d.addr4 = 1'b0;
                lock_clr   = 1'b1;
            end else if (cls.wen) begin
                st_d.wel = 1'b1;
            end else if (cls.wdis) begin
                st_d.wel = 1'b0;
            end else if (cls.clrflg) begin
                st_d.perr = 1'b0;
                st_d.eerr = 1'b0;
            end else if (cls.resume) begin
                st_d.susp = 1'b0;
            end else if (cls.rd) begin
                if (st_q.susp && (st_q.act_kind == K_PROG) &&
                    (cmd_page == st_q.act_page)) begin
                    st_d.refuse = 1'b1;
                end else begin
                    st_d.go      = 1'b1;
                    st_d.go_kind = K_READ;
                end
            end else if ((cls.prog || cls.erase) && st_q.wel) begin
                if (st_q.susp || st_q.act_v) begin
                    st_d.refuse = 1'b1;
                end else if (prot_w || lock_w) begin
                    st_d.refuse = 1'b1;
                    st_d.wel    = 1'b0;
                    if (cls.prog) begin
                        st_d.perr = 1'b1;
                    end else begin
                        st_d.eerr = 1'b1;
                    end
                end else begin
                    st_d.go       = 1'b1;
                    st_d.go_kind  = cls.prog ? K_PROG : K_ERASE;
                    st_d.act_v    = 1'b1;
                    st_d.act_kind = cls.prog ? K_PROG : K_ERASE;
                    st_d.act_page = cmd_page;
                end
            end else if (cls.wrsr && st_q.wel) begin
                st_d.bp  = cmd_wdata[3:0];
                st_d.tb  = cmd_wdata[4];
                st_d.wel = 1'b0;
            end else if (cls.wrlock && st_q.wel) begin
                lock_we  = 1'b1;
                st_d.wel = 1'b0;
            end else if ((cls.en4b || cls.ex4b) && st_q.wel) begin
                st_d.addr4 = cls.en4b;
                st_d.wel   = 1'b0;
            end
        end

        // Completion of the operation in flight.
        if (op_done && st_q.act_v && !st_q.susp) begin
            st_d.wel   = 1'b0;
            st_d.act_v = 1'b0;
            if (op_fail) begin
                if (st_q.act_kind == K_PROG) begin
                    st_d.perr = 1'b1;
                end else begin
                    st_d.eerr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.act_kind <= K_NONE;
            st_q.go_kind  <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel_o        = st_q.wel;
    assign bp_o         = st_q.bp;
    assign tb_o         = st_q.tb;
    assign addr4_o      = st_q.addr4;
    assign go_o         = st_q.go;
    assign go_kind_o    = st_q.go_kind;
    assign refuse_o     = st_q.refuse;
    assign prog_err_o   = st_q.perr;
    assign erase_err_o  = st_q.eerr;
    assign prog_susp_o  = st_q.susp && (st_q.act_kind == K_PROG);
    assign erase_susp_o = st_q.susp && (st_q.act_kind == K_ERASE);
    assign soft_reset_o = st_q.srst;

    // R1: an accepted write-type request always saw the latch set.
    a_r1_go_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && (go_kind_o != K_READ)) |-> wel_o);

    // R2: a torn frame moves nothing visible.
    a_r2_torn_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_aligned && !op_done) |=>
        ($stable(wel_o) && $stable(bp_o) && $stable(tb_o) && !go_o && !refuse_o));

    // R3: level 0 shields nothing, levels 10..15 shield every sector.
    a_r3_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_o == 4'd0) |-> !prot_w);
    a_r3_level_full: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_o >= 4'd10) |-> prot_w);

    // R6: a reset fires only from an armed state.
    a_r6_reset_armed: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |-> $past(st_q.arm));

    // R7: no erase is granted while an erase is suspended.
    a_r7_no_erase_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
        erase_susp_o |-> !(go_o && (go_kind_o == K_ERASE)));

    // R9: completion drops the latch.
    a_r9_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && st_q.act_v && !st_q.susp) |=> !wel_o);

    // R12: verdict pulses are exclusive.
    a_r12_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_o, refuse_o, soft_reset_o}));

endmodule

// File: tb/nor_write_guard_tb.sv
module nor_write_guard_tb;

    localparam int PAGE_W = 17;
    localparam int NSEC   = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_aligned = 1'b1;
    logic [7:0]        cmd_op = 8'h00;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic [4:0]        cmd_wdata = '0;
    logic              busy_i = 1'b0;
    logic              op_done = 1'b0;
    logic              op_fail = 1'b0;
    logic              wel_o, tb_o, addr4_o, go_o, refuse_o;
    logic [3:0]        bp_o;
    logic [1:0]        go_kind_o;
    logic              prog_err_o, erase_err_o, prog_susp_o, erase_susp_o, soft_reset_o;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state kept by the bench.
    bit              m_wel, m_tb, m_addr4, m_perr, m_eerr, m_arm, m_act, m_susp;
    bit [3:0]        m_bp;
    int              m_kind;
    bit [PAGE_W-1:0] m_page;
    bit              m_lock [NSEC];
    bit              e_go, e_ref, e_srst;
    int              e_kind;

    always #5 clk = ~clk;

    nor_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_aligned(cmd_aligned),
        .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_wdata(cmd_wdata), .busy_i(busy_i),
        .op_done(op_done), .op_fail(op_fail), .wel_o(wel_o), .bp_o(bp_o), .tb_o(tb_o),
        .addr4_o(addr4_o), .go_o(go_o), .go_kind_o(go_kind_o), .refuse_o(refuse_o),
        .prog_err_o(prog_err_o), .erase_err_o(erase_err_o), .prog_susp_o(prog_susp_o),
        .erase_susp_o(erase_susp_o), .soft_reset_o(soft_reset_o)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit shielded(input bit [3:0] bp, input bit tb, input int sec);
        int size;
        if (bp == 0) return 1'b0;
        size = (bp >= 10) ? NSEC : (1 << (bp - 1));
        return tb ? (sec < size) : (sec >= NSEC - size);
    endfunction

    task automatic model_reset();
        m_wel = 0; m_tb = 0; m_addr4 = 0; m_perr = 0; m_eerr = 0;
        m_arm = 0; m_act = 0; m_susp = 0; m_bp = 0; m_kind = 3; m_page = '0;
        for (int i = 0; i < NSEC; i++) m_lock[i] = 1'b0;
    endtask

    task automatic model(input bit v, input bit al, input bit [7:0] op,
                         input bit [PAGE_W-1:0] pg, input bit [4:0] wd,
                         input bit dn, input bit fl);
        bit pre_act, pre_susp, busy;
        int sec;
        pre_act = m_act; pre_susp = m_susp;
        busy = m_act && !m_susp;
        sec = int'(pg[PAGE_W-1 -: 9]);
        e_go = 0; e_ref = 0; e_srst = 0; e_kind = 3;
        if (v && al) begin
            if (!(op == 8'h99 && m_arm)) m_arm = 0;
            if (busy) begin
                if (op == 8'h75 && m_act) m_susp = 1;
            end else begin
                case (op)
                    8'h66: m_arm = 1;
                    8'h99: if (m_arm) begin
                        m_arm = 0; e_srst = 1; m_wel = 0; m_perr = 0; m_eerr = 0;
                        m_susp = 0; m_act = 0; m_addr4 = 0;
                        for (int i = 0; i < NSEC; i++) m_lock[i] = 1'b0;
                    end
                    8'h06: m_wel = 1;
                    8'h04: m_wel = 0;
                    8'h50: begin m_perr = 0; m_eerr = 0; end
                    8'h7A: m_susp = 0;
                    8'h03: begin
                        if (m_susp && m_kind == 1 && pg == m_page) e_ref = 1;
                        else begin e_go = 1; e_kind = 0; end
                    end
                    8'h02, 8'hD8: if (m_wel) begin
                        if (m_susp || m_act) e_ref = 1;
                        else if (shielded(m_bp, m_tb, sec) || m_lock[sec]) begin
                            e_ref = 1; m_wel = 0;
                            if (op == 8'h02) m_perr = 1; else m_eerr = 1;
                        end else begin
                            e_go = 1; e_kind = (op == 8'h02) ? 1 : 2;
                            m_act = 1; m_kind = e_kind; m_page = pg;
                        end
                    end
                    8'h01: if (m_wel) begin m_bp = wd[3:0]; m_tb = wd[4]; m_wel = 0; end
                    8'hE5: if (m_wel) begin m_lock[sec] = wd[0]; m_wel = 0; end
                    8'hB7, 8'hE9: if (m_wel) begin m_addr4 = (op == 8'hB7); m_wel = 0; end
                    default: ;
                endcase
            end
        end
        if (dn && pre_act && !pre_susp) begin
            m_wel = 0; m_act = 0;
            if (fl) begin
                if (m_kind == 1) m_perr = 1; else m_eerr = 1;
            end
        end
    endtask

    task automatic compare_all();
        cmp("R1", "wel", wel_o, m_wel);
        cmp("R3", "bp", bp_o, m_bp);
        cmp("R3", "tb", tb_o, m_tb);
        cmp("R11", "addr4", addr4_o, m_addr4);
        cmp("R4", "go", go_o, e_go);
        cmp("R4", "refuse", refuse_o, e_ref);
        if (e_go) cmp("R8", "go kind", go_kind_o, e_kind);
        cmp("R9", "prog err", prog_err_o, m_perr);
        cmp("R9", "erase err", erase_err_o, m_eerr);
        cmp("R7", "prog susp", prog_susp_o, m_susp && m_kind == 1);
        cmp("R7", "erase susp", erase_susp_o, m_susp && m_kind == 2);
        cmp("R6", "soft reset", soft_reset_o, e_srst);
    endtask

    // One clock of stimulus; outputs are sampled one edge later (R12).
    task automatic step(input bit v, input bit al, input bit [7:0] op,
                        input bit [PAGE_W-1:0] pg, input bit [4:0] wd,
                        input bit dn, input bit fl);
        @(negedge clk);
        busy_i = m_act && !m_susp;
        cmd_valid = v; cmd_aligned = al; cmd_op = op; cmd_page = pg; cmd_wdata = wd;
        op_done = dn; op_fail = fl;
        model(v, al, op, pg, wd, dn, fl);
        @(negedge clk);
        cmd_valid = 1'b0; op_done = 1'b0; op_fail = 1'b0;
        busy_i = m_act && !m_susp;
        compare_all();
    endtask

    task automatic cmd(input bit [7:0] op, input int sec, input bit [4:0] wd);
        step(1'b1, 1'b1, op, PAGE_W'(sec << 8), wd, 1'b0, 1'b0);
    endtask

    task automatic done(input bit fl);
        step(1'b0, 1'b1, 8'h00, '0, '0, 1'b1, fl);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int sec_pick [7];
        void'($urandom(32'd20240611));
        sec_pick = '{0, 1, 255, 256, 510, 511, 7};
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        cmp("R5", "reset go_kind", go_kind_o, 3);

        // R1: program with the latch clear does nothing.
        cmd(8'h02, 100, 0);
        cmp("R1", "no verdict without latch", go_o | refuse_o, 0);
        cmd(8'h06, 0, 0);
        cmd(8'h04, 0, 0);
        cmp("R1", "latch cleared by 04h", wel_o, 0);

        // R2: torn frames.
        step(1'b1, 1'b0, 8'h06, '0, '0, 1'b0, 1'b0);
        cmp("R2", "torn 06h keeps latch", wel_o, 0);
        cmd(8'h06, 0, 0);
        step(1'b1, 1'b0, 8'h02, PAGE_W'(3 << 8), '0, 1'b0, 1'b0);
        cmp("R2", "torn program keeps latch and gives no pulse", {wel_o, go_o, refuse_o}, 3'b100);

        // R3/R4: top-one-sector range.
        cmd(8'h01, 0, 5'h01);
        cmd(8'h06, 0, 0);
        cmd(8'h02, 511, 0);
        cmp("R4", "program to sector 511 refused", {refuse_o, prog_err_o, wel_o}, 3'b110);
        cmd(8'h06, 0, 0);
        cmd(8'h02, 510, 0);
        cmp("R4", "program to sector 510 granted", {go_o, go_kind_o}, 3'b101);
        done(1'b0);
        cmp("R9", "done clears latch", wel_o, 0);
        cmd(8'h50, 0, 0);

        // R3: bottom range, level 9 and full level.
        cmd(8'h06, 0, 0);
        cmd(8'h01, 0, 5'h19);
        cmd(8'h06, 0, 0);
        cmd(8'hD8, 255, 0);
        cmp("R3", "bottom level 9 shields 255", {refuse_o, erase_err_o}, 2'b11);
        cmd(8'h06, 0, 0);
        cmd(8'hD8, 256, 0);
        cmp("R3", "bottom level 9 leaves 256", go_o, 1);
        done(1'b1);
        cmp("R9", "failed erase flags", erase_err_o, 1);
        cmd(8'h50, 0, 0);
        cmd(8'h06, 0, 0);
        cmd(8'h01, 0, 5'h0A);
        cmd(8'h06, 0, 0);
        cmd(8'h02, 0, 0);
        cmp("R3", "level 10 shields sector 0", refuse_o, 1);

        // R5: lock bit.
        cmd(8'h06, 0, 0);
        cmd(8'h01, 0, 5'h00);
        cmd(8'h06, 0, 0);
        cmd(8'hE5, 7, 5'h01);
        cmd(8'h06, 0, 0);
        cmd(8'hD8, 7, 0);
        cmp("R5", "locked sector refused", {refuse_o, erase_err_o}, 2'b11);

        // R6: disarmed reset, then real reset.
        cmd(8'h66, 0, 0);
        cmd(8'h05, 0, 0);
        cmd(8'h99, 0, 0);
        cmp("R6", "disarmed 99h", soft_reset_o, 0);
        cmd(8'h66, 0, 0);
        cmd(8'h99, 0, 0);
        cmp("R6", "armed 99h fires and clears flag", {soft_reset_o, erase_err_o}, 2'b10);
        cmd(8'h06, 0, 0);
        cmd(8'hD8, 7, 0);
        cmp("R6", "lock cleared by reset", go_o, 1);
        done(1'b0);

        // R7/R8/R10: suspend around a program.
        cmd(8'h06, 0, 0);
        cmd(8'hB7, 0, 0);
        cmp("R11", "four-byte mode", addr4_o, 1);
        cmd(8'h06, 0, 0);
        step(1'b1, 1'b1, 8'h02, 17'h0A012, '0, 1'b0, 1'b0);
        cmd(8'h04, 0, 0);
        cmp("R10", "04h ignored while busy", wel_o, 1);
        cmd(8'h75, 0, 0);
        cmp("R7", "program suspended", prog_susp_o, 1);
        step(1'b1, 1'b1, 8'h03, 17'h0A012, '0, 1'b0, 1'b0);
        cmp("R8", "read of suspended page refused", refuse_o, 1);
        step(1'b1, 1'b1, 8'h03, 17'h0A013, '0, 1'b0, 1'b0);
        cmp("R8", "read of other page granted", {go_o, go_kind_o}, 3'b100);
        cmd(8'hD8, 300, 0);
        cmp("R7", "erase refused in suspension, latch kept", {refuse_o, wel_o, erase_err_o}, 3'b110);
        cmd(8'h7A, 0, 0);
        cmp("R7", "resumed", prog_susp_o, 0);
        done(1'b1);
        cmp("R9", "failed program flags", prog_err_o, 1);

        // Random mix.
        for (int it = 0; it < 1500; it++) begin
            bit [7:0] ops [17];
            bit [7:0] op;
            int sec;
            ops = '{8'h06, 8'h06, 8'h04, 8'h03, 8'h02, 8'hD8, 8'h01, 8'hE5, 8'h66,
                    8'h99, 8'h75, 8'h7A, 8'h50, 8'hB7, 8'hE9, 8'h05, 8'h00};
            if (m_act && !m_susp && ($urandom % 5 == 0)) begin
                done(1'($urandom % 2));
            end else begin
                op = ops[$urandom % 17];
                if (op == 8'h00) op = 8'($urandom);
                sec = ($urandom % 2) ? sec_pick[$urandom % 7] : int'($urandom % NSEC);
                step(1'b1, ($urandom % 10) != 0, op,
                     PAGE_W'((sec << 8) | ($urandom % 4)), 5'($urandom), 1'b0, 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule